// File: doc/BRIEF.md
# Burst-Mode Shared Memory Port

This block puts a shared 16-bit data RAM behind two I/O port numbers on a common processor bus. No address is sent with each word. A processor first writes a start address to the pointer port. That write loads an internal address counter. After that, each access to the data port moves one word at the counter's address, and the counter then advances by one. A processor that holds the bus can therefore stream a block of words in or out with one address write followed by a run of data accesses. This burst path is the only way to reach the RAM.

Each access is a single cycle with `acc_en_i` high. The port number and the direction come with it. Reads return registered data one cycle later, flagged by `rd_valid_o`. A read of the pointer port returns the live counter value, so software can find where a burst stopped. The counter is `ADDR_W` bits wide (up to 15, for 32K words) and wraps from its all-ones value to zero. The RAM is modelled inside the block and is written so that block RAM can be inferred. Bus arbitration lies outside this block.

Top module: `burst_mem_port`

## Requirements
- R1: A synchronous active-high reset clears the address counter to zero, drives `rd_valid_o` low and drives `rd_data_o` to zero.
- R2: An access with `acc_en_i`=1, `wr_i`=1 and `port_i`=PTR_PORT (default 1) loads the counter from the low `ADDR_W` bits of `wr_data_i`; the upper bits are ignored.
- R3: An access with `acc_en_i`=1, `wr_i`=0 and `port_i`=PTR_PORT returns the counter value, zero-extended, on `rd_data_o`, with `rd_valid_o`=1 on the next cycle; the counter is unchanged.
- R4: An access with `acc_en_i`=1, `wr_i`=1 and `port_i`=DAT_PORT (default 2) writes `wr_data_i` to the RAM word at the counter and then adds one to the counter.
- R5: An access with `acc_en_i`=1, `wr_i`=0 and `port_i`=DAT_PORT returns the RAM word at the counter on `rd_data_o`, with `rd_valid_o`=1 on the next cycle, and then adds one to the counter.
- R6: The counter wraps from 2^ADDR_W-1 to 0 on a data-port access.
- R7: An access to any other port number changes neither the RAM nor the counter, and produces no `rd_valid_o`.
- R8: While `acc_en_i`=0, the values on `port_i`, `wr_i` and `wr_data_i` have no effect, and `rd_valid_o` stays 0.
- R9: `rd_data_o` holds its last value in every cycle in which `rd_valid_o` is 0.
- R10: Back-to-back data-port accesses on consecutive cycles each move one word at consecutive addresses, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en_i | input | 1 | Access strobe, one cycle per access |
| port_i | input | PORT_W | I/O port number of the access |
| wr_i | input | 1 | Direction: 1 means write, 0 means read |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, registered |
| rd_valid_o | output | 1 | High one cycle after a pointer-port or data-port read |

## Verification
Checked every cycle:
- The counter's response to each kind of access: loaded from the bus, one more (with wrap), or unchanged.
- The one-cycle read-valid timing.
- The zero-extended counter value returned on a pointer-port read.
- That the output stays steady when no read returns.

Shown only by the bench's scenarios:
- That data words land at the right addresses and come back later unchanged. This needs a reference memory.
- That foreign-port writes leave the RAM intact.
- That a long burst crosses the wrap point correctly.
- That random mixes of pointer loads, streaming writes and streaming reads agree with the model.

// File: rtl/burst_mem_pkg.sv
package burst_mem_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PTR_WR  = 3'd1,
    OP_PTR_RD  = 3'd2,
    OP_DAT_WR  = 3'd3,
    OP_DAT_RD  = 3'd4
  } bus_op_e;

endpackage

// File: rtl/bmp_port_decode.sv
module bmp_port_decode
  import burst_mem_pkg::*;
#(
  parameter int PORT_W   = 4,
  parameter int PTR_PORT = 1,
  parameter int DAT_PORT = 2
) (
  input  logic              acc_en_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              wr_i,
  output bus_op_e           op_o
);

  localparam logic [PORT_W-1:0] PtrNum = PORT_W'(PTR_PORT);
  localparam logic [PORT_W-1:0] DatNum = PORT_W'(DAT_PORT);

  always_comb begin
    op_o = OP_IDLE;
    if (acc_en_i) begin
      if (port_i == PtrNum) begin
        op_o = wr_i ? OP_PTR_WR : OP_PTR_RD;
      end else if (port_i == DatNum) begin
        op_o = wr_i ? OP_DAT_WR : OP_DAT_RD;
      end
    end
  end

endmodule

// File: rtl/bmp_addr_counter.sv
module bmp_addr_counter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cnt_o
);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/bmp_sp_ram.sv
module bmp_sp_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_q <= mem[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/burst_mem_port.sv
module burst_mem_port
  import burst_mem_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int PORT_W   = 4,
  parameter int PTR_PORT = 1,
  parameter int DAT_PORT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  bus_op_e           op;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptr_load_val;
  logic [DATA_W-1:0] ptr_ext;
  logic [DATA_W-1:0] ram_rdata;
  logic              ptr_load;
  logic              ptr_step;
  logic              ram_we;
  logic              ram_re;

  logic              rd_valid_q;
  logic              rd_from_ptr_q;
  logic [DATA_W-1:0] ptr_snap_q;

  bmp_port_decode #(
    .PORT_W   (PORT_W),
    .PTR_PORT (PTR_PORT),
    .DAT_PORT (DAT_PORT)
  ) u_decode (
    .acc_en_i (acc_en_i),
    .port_i   (port_i),
    .wr_i     (wr_i),
    .op_o     (op)
  );

  assign ptr_load = (op == OP_PTR_WR);
  assign ram_we   = (op == OP_DAT_WR);
  assign ram_re   = (op == OP_DAT_RD);
  assign ptr_step = ram_we || ram_re;

  generate
    if (DATA_W > ADDR_W) begin : g_pad
      assign ptr_load_val = wr_data_i[ADDR_W-1:0];
      assign ptr_ext      = {{(DATA_W-ADDR_W){1'b0}}, ptr};
    end else begin : g_trunc
      logic [ADDR_W-1:0] wide_data;
      assign wide_data    = ADDR_W'(wr_data_i);
      assign ptr_load_val = wide_data;
      assign ptr_ext      = ptr[DATA_W-1:0];
    end
  endgenerate

  bmp_addr_counter #(
    .ADDR_W (ADDR_W)
  ) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ptr_load),
    .load_val_i (ptr_load_val),
    .step_i     (ptr_step),
    .cnt_o      (ptr)
  );

  bmp_sp_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .addr_i  (ptr),
    .wdata_i (wr_data_i),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q    <= 1'b0;
      rd_from_ptr_q <= 1'b1;
      ptr_snap_q    <= '0;
    end else begin
      rd_valid_q <= (op == OP_PTR_RD) || ram_re;
      if (op == OP_PTR_RD) begin
        rd_from_ptr_q <= 1'b1;
        ptr_snap_q    <= ptr_ext;
      end else if (ram_re) begin
        rd_from_ptr_q <= 1'b0;
      end
    end
  end

  assign rd_data_o  = rd_from_ptr_q ? ptr_snap_q : ram_rdata;
  assign rd_valid_o = rd_valid_q;

endmodule

// File: rtl/burst_mem_port_chk.sv
module burst_mem_port_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int PORT_W   = 4,
  parameter int PTR_PORT = 1,
  parameter int DAT_PORT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en_i,
  input logic [PORT_W-1:0] port_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] ptr
);

  logic is_ptr;
  logic is_dat;
  assign is_ptr = acc_en_i && (port_i == PORT_W'(PTR_PORT));
  assign is_dat = acc_en_i && (port_i == PORT_W'(DAT_PORT));

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ptr == '0) && !rd_valid_o && (rd_data_o == '0));

  // R2
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
    (is_ptr && wr_i) |=> (ptr == $past(wr_data_i[ADDR_W-1:0])));

  // R3
  p_ptr_read_r3: assert property (@(posedge clk) disable iff (rst)
    (is_ptr && !wr_i) |=> rd_valid_o && $stable(ptr)
                          && (rd_data_o == DATA_W'($past(ptr))));

  // R4, R6
  p_dat_write_step_r4: assert property (@(posedge clk) disable iff (rst)
    (is_dat && wr_i) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)) && !rd_valid_o);

  // R5, R6, R10
  p_dat_read_step_r5: assert property (@(posedge clk) disable iff (rst)
    (is_dat && !wr_i) |=> rd_valid_o && (ptr == ADDR_W'($past(ptr) + 1'b1)));

  // R7
  p_foreign_port_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_en_i && !is_ptr && !is_dat) |=> $stable(ptr) && !rd_valid_o);

  // R8
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_en_i |=> $stable(ptr) && !rd_valid_o);

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> $stable(rd_data_o));

endmodule

bind burst_mem_port burst_mem_port_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .PORT_W   (PORT_W),
  .PTR_PORT (PTR_PORT),
  .DAT_PORT (DAT_PORT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_en_i   (acc_en_i),
  .port_i     (port_i),
  .wr_i       (wr_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .ptr        (ptr)
);

// File: tb/burst_mem_port_tb.sv
module burst_mem_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 10;
  localparam int PORT_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam logic [PORT_W-1:0] PTR = 4'd1;
  localparam logic [PORT_W-1:0] DAT = 4'd2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              acc_en = 1'b0;
  logic [PORT_W-1:0] port = '0;
  logic              wr = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [ADDR_W-1:0] ref_ptr;
  logic [DATA_W-1:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_mem_port u_dut (
    .clk        (clk),
    .rst        (rst),
    .acc_en_i   (acc_en),
    .port_i     (port),
    .wr_i       (wr),
    .wr_data_i  (wdata),
    .rd_data_o  (rdata),
    .rd_valid_o (rvalid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] ptr_word(input logic [ADDR_W-1:0] p);
    return DATA_W'(p);
  endfunction

  // one access cycle; outputs of this access are checked at the following negedge
  task automatic acc(input logic [PORT_W-1:0] p, input logic w,
                     input logic [DATA_W-1:0] d, input string tag);
    logic              exp_v;
    logic [DATA_W-1:0] exp_d;
    exp_v = 1'b0;
    exp_d = last_rd;
    acc_en = 1'b1; port = p; wr = w; wdata = d;
    if (p == PTR) begin
      if (w) ref_ptr = d[ADDR_W-1:0];
      else begin exp_v = 1'b1; exp_d = ptr_word(ref_ptr); end
    end else if (p == DAT) begin
      if (w) ref_mem[ref_ptr] = d;
      else begin exp_v = 1'b1; exp_d = ref_mem[ref_ptr]; end
      ref_ptr = ref_ptr + 1'b1;
    end
    @(negedge clk);
    chk({tag, " valid"}, 32'(rvalid), 32'(exp_v));
    chk({tag, " data"}, 32'(rdata), 32'(exp_d));
    last_rd = exp_d;
  endtask

  task automatic idle(input string tag);
    acc_en = 1'b0;
    port = PORT_W'($urandom);
    wr = 1'($urandom);
    wdata = DATA_W'($urandom);
    @(negedge clk);
    chk({tag, " valid"}, 32'(rvalid), 32'd0);
    chk({tag, " data"}, 32'(rdata), 32'(last_rd));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] saved;
    logic [ADDR_W-1:0] base;
    void'($urandom(32'd1234));
    ref_ptr = '0;
    last_rd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(rvalid), 32'd0);
    chk("R1 data", 32'(rdata), 32'd0);
    acc(PTR, 1'b0, '0, "R1 ptr after reset");
    idle("R8 idle");

    // R4, R10: fill the whole RAM in one back-to-back burst from 0
    acc(PTR, 1'b1, '0, "R2 load zero");
    for (int i = 0; i < DEPTH; i++) acc(DAT, 1'b1, DATA_W'($urandom), "R4 fill");
    // R6: DEPTH steps from 0 wrap the pointer back to 0
    acc(PTR, 1'b0, '0, "R6 wrap after fill");

    // R2: upper bits ignored on load; R3 readback
    acc(PTR, 1'b1, 16'hFC35, "R2 masked load");
    acc(PTR, 1'b0, '0, "R3 ptr readback");
    // R5, R10: back-to-back read burst
    for (int i = 0; i < 8; i++) acc(DAT, 1'b0, '0, "R5 read burst");
    acc(PTR, 1'b0, '0, "R5 ptr after burst");
    idle("R9 hold");

    // R6: wrap at the top address on a read and on a write
    acc(PTR, 1'b1, 16'(DEPTH - 1), "R6 load top");
    acc(DAT, 1'b0, '0, "R6 read top");
    acc(PTR, 1'b0, '0, "R6 wrapped read");
    acc(PTR, 1'b1, 16'(DEPTH - 1), "R6 load top");
    acc(DAT, 1'b1, 16'hBEEF, "R6 write top");
    acc(DAT, 1'b1, 16'h1357, "R6 write zero");
    acc(PTR, 1'b1, 16'(DEPTH - 1), "R6 reload top");
    acc(DAT, 1'b0, '0, "R6 read back top");
    acc(DAT, 1'b0, '0, "R6 read back zero");

    // R7: foreign ports touch neither RAM nor pointer
    base = ADDR_W'(37);
    acc(PTR, 1'b1, 16'(base), "R7 setup");
    saved = ref_mem[base];
    acc(4'd0, 1'b1, 16'hDEAD, "R7 foreign write p0");
    acc(4'd3, 1'b1, 16'hDEAD, "R7 foreign write p3");
    acc(4'd15, 1'b0, '0, "R7 foreign read p15");
    acc(PTR, 1'b0, '0, "R7 ptr unchanged");
    acc(DAT, 1'b0, '0, "R7 ram unchanged");
    chk("R7 ref intact", 32'(ref_mem[base]), 32'(saved));

    // R8: idle cycles with random bus noise
    for (int i = 0; i < 20; i++) idle("R8 noise");
    acc(PTR, 1'b0, '0, "R8 ptr unchanged");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) acc(PTR, 1'b1, DATA_W'($urandom), "R2 rand load");
      else if (sel == 1) acc(PTR, 1'b0, '0, "R3 rand ptr read");
      else if (sel < 5) acc(DAT, 1'b1, DATA_W'($urandom), "R4 rand write");
      else if (sel < 8) acc(DAT, 1'b0, '0, "R5 rand read");
      else if (sel == 8) acc(PORT_W'($urandom_range(3, 15)), 1'($urandom),
                             DATA_W'($urandom), "R7 rand foreign");
      else idle("R8 rand idle");
    end
    idle("R9 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule